// File: doc/BRIEF.md
# Register Stack Save/Restore Sequencer

This block moves a chosen set of processor registers between the register file and a stack in memory, one 32-bit word per memory transaction. A one-cycle start pulse supplies an 8-bit selection mask, a direction (save or restore) and the current stack pointer. The sequencer then walks the selected registers in a fixed order. It reads or writes the register file through a simple indexed port and moves each word over a request/acknowledge memory port.

A save moves the pointer downwards and a restore moves it upwards. The restore order is the exact reverse of the save order, so a restore with the same mask undoes a save. The stack pointer is never changed while the operation runs. The final value is handed back once, in a single write-back cycle, after the last word has moved. The upper four mask bits each pick one register. One further bit picks a fixed group of seven registers, and that group also takes up one padding word that is never transferred.

Top module: `regstack_seq`

## Requirements
- R1: Register indices on the register-file port are D0..D3 = 0..3, A0..A3 = 4..7, MDR = 8, LIR = 9, LAR = 10. Mask bit 7 selects D2, bit 6 selects D3, bit 5 selects A2, bit 4 selects A3, and bit 3 selects the group {D0, D1, A0, A1, MDR, LIR, LAR}.
- R2: A save (pushDir = 1) stores in the order D2, D3, A2, A3, then D0, D1, A0, A1, MDR, LIR, LAR. Registers that are not selected are skipped. Before each store the pointer drops by 4, and the word is written at the new pointer.
- R3: After the group selected by bit 3 has been stored, a save lowers the pointer by 4 more, with no memory access.
- R4: A restore (pushDir = 0) first raises the pointer by 4 with no access if bit 3 is set. It then loads LAR, LIR, MDR, A1, A0, D1, D0, then A3, A2, D3, D2, skipping registers that are not selected. Each load reads the current pointer, and the pointer then rises by 4. Every loaded word is written into the named register.
- R5: spWe pulses for exactly one cycle per operation, after the last transfer. In that cycle spOut carries the final pointer.
- R6: Mask bits 2 to 0 have no effect.
- R7: busy is high from the cycle after start is accepted through the write-back cycle. A start pulse while busy is high is ignored.
- R8: While memReq is high and memAck is low, memReq, memAddr and memWe hold their values. Stalls lengthen the operation but never change the order of transfers.
- R9: When no register is selected, spWe rises in the first cycle after start, spOut equals spIn, and no memory request is made.
- R10: A save never writes the register file. The register file is written only in a cycle where a load is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| pushDir | input | 1 | 1 = save to stack, 0 = restore from stack |
| regMask | input | 8 | Register selection mask |
| spIn | input | 32 | Stack pointer sampled at start |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word byte address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data, valid with memAck |
| memAck | input | 1 | Completes the current request |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdata | input | 32 | Register-file read data (combinational) |
| rfWe | output | 1 | Register-file write strobe |
| rfWrIdx | output | 4 | Register-file write index |
| rfWdata | output | 32 | Register-file write data |
| spWe | output | 1 | Stack pointer write-back strobe |
| spOut | output | 32 | Final stack pointer |

## Verification
Two events can fall in the same cycle: an acknowledged memory word and the step to the next register. On a restore, a third joins them: the write to the register file. The padding step can also sit directly next to the final write-back. Random acknowledge density (including heavy stalls) together with masks that mix the group bit and single bits drives these coincidences. Each run is judged by comparing the recorded address, direction, register and data of every word, the final pointer, and the register file afterwards against a model built from the order rules.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  localparam int MASK_W     = 8;
  localparam int NUM_STEPS  = 12;
  localparam int STEP_W     = $clog2(NUM_STEPS);
  localparam int RIDX_W     = 4;
  localparam int SINGLE_CNT = 4;
  localparam int GROUP_BIT  = 3;
  localparam int PAD_ENTRY  = NUM_STEPS - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WB} seqState_t;

  typedef struct packed {
    logic              latch;
    logic              advance;
    logic              memReq;
    logic              isPush;
    logic              writeBack;
    logic [STEP_W-1:0] entry;
  } seqStrobe_t;

  // Save-order entry to register index; restore walks the entries backwards.
  function automatic logic [RIDX_W-1:0] entryReg(input logic [STEP_W-1:0] e);
    case (e)
      4'd0:    entryReg = 4'd2;
      4'd1:    entryReg = 4'd3;
      4'd2:    entryReg = 4'd6;
      4'd3:    entryReg = 4'd7;
      4'd4:    entryReg = 4'd0;
      4'd5:    entryReg = 4'd1;
      4'd6:    entryReg = 4'd4;
      4'd7:    entryReg = 4'd5;
      4'd8:    entryReg = 4'd8;
      4'd9:    entryReg = 4'd9;
      4'd10:   entryReg = 4'd10;
      default: entryReg = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
  import regstack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pushDir,
  input  logic [MASK_W-1:0] regMask,
  input  logic              memAck,
  output seqStrobe_t        strobe,
  output logic              busy
);
  seqState_t          state;
  logic [NUM_STEPS-1:0] pend, entryEn, startPend, curOh;
  logic               dirPush;
  logic [STEP_W-1:0]  curK, entry;
  logic               padStep, xferDone, lastStep;
  logic               unusedLowBits;

  assign unusedLowBits = ^regMask[GROUP_BIT-1:0];

  // Enable per save-order entry: four single bits, then the group (with pad).
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_entryEn
    if (i < SINGLE_CNT) begin : g_single
      assign entryEn[i] = regMask[MASK_W-1-i];
    end else begin : g_group
      assign entryEn[i] = regMask[GROUP_BIT];
    end
  end

  // Pending vector is kept in walk order for the chosen direction.
  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_order
    assign startPend[k] = pushDir ? entryEn[k] : entryEn[NUM_STEPS-1-k];
  end

  always_comb begin
    curK = '0;
    for (int i = NUM_STEPS - 1; i >= 0; i--) begin
      if (pend[i]) curK = STEP_W'(i);
    end
  end

  assign curOh    = pend & (~pend + 1'b1);
  assign lastStep = (pend & ~curOh) == '0;
  assign entry    = dirPush ? curK : STEP_W'(NUM_STEPS - 1) - curK;
  assign padStep  = (entry == STEP_W'(PAD_ENTRY));
  assign xferDone = (state == ST_XFER) && (padStep || memAck);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pend    <= '0;
      dirPush <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          dirPush <= pushDir;
          pend    <= startPend;
          state   <= (startPend == '0) ? ST_WB : ST_XFER;
        end
        ST_XFER: if (xferDone) begin
          pend <= pend & ~curOh;
          if (lastStep) state <= ST_WB;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.latch     = (state == ST_IDLE) && start;
  assign strobe.advance   = xferDone;
  assign strobe.memReq    = (state == ST_XFER) && !padStep;
  assign strobe.isPush    = dirPush;
  assign strobe.writeBack = (state == ST_WB);
  assign strobe.entry     = entry;
  assign busy             = (state != ST_IDLE);

  assert_busy_until_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.writeBack) |=> busy);
  assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |=> (!strobe.writeBack && !busy));
  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strobe.memReq);
endmodule

// File: rtl/regstack_dp.sv
module regstack_dp
  import regstack_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rfRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [RIDX_W-1:0] rfRdIdx,
  output logic              rfWe,
  output logic [RIDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0] rfWdata,
  output logic              spWe,
  output logic [ADDR_W-1:0] spOut
);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] ptr, ptrDown, ptrUp;
  logic [RIDX_W-1:0] curReg;

  assign ptrDown = ptr - STEP_BYTES;
  assign ptrUp   = ptr + STEP_BYTES;
  assign curReg  = entryReg(strobe.entry);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.latch) begin
      ptr <= spIn;
    end else if (strobe.advance) begin
      ptr <= strobe.isPush ? ptrDown : ptrUp;
    end
  end

  assign memReq   = strobe.memReq;
  assign memWe    = strobe.memReq && strobe.isPush;
  assign memAddr  = strobe.isPush ? ptrDown : ptr;
  assign memWdata = rfRdata;
  assign rfRdIdx  = curReg;
  assign rfWrIdx  = curReg;
  assign rfWdata  = memRdata;
  assign rfWe     = strobe.advance && strobe.memReq && !strobe.isPush;
  assign spWe     = strobe.writeBack;
  assign spOut    = ptr;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
  assert_rf_write_load_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> (memReq && memAck && !memWe));
  assert_ptr_frozen_at_wb_R5: assert property (@(posedge clk) disable iff (!rstN)
    spWe |=> $stable(spOut));
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import regstack_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pushDir,
  input  logic [MASK_W-1:0] regMask,
  input  logic [ADDR_W-1:0] spIn,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [RIDX_W-1:0] rfRdIdx,
  input  logic [DATA_W-1:0] rfRdata,
  output logic              rfWe,
  output logic [RIDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0] rfWdata,
  output logic              spWe,
  output logic [ADDR_W-1:0] spOut
);
  seqStrobe_t strobe;

  regstack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pushDir(pushDir),
    .regMask(regMask), .memAck(memAck), .strobe(strobe), .busy(busy)
  );

  regstack_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spIn(spIn), .memAck(memAck),
    .memRdata(memRdata), .rfRdata(rfRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .rfRdIdx(rfRdIdx), .rfWe(rfWe),
    .rfWrIdx(rfWrIdx), .rfWdata(rfWdata), .spWe(spWe), .spOut(spOut)
  );
endmodule

// File: tb/tb_regstack_seq.sv
module tb_regstack_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, pushDir = 1'b0;
  logic [7:0]  regMask = '0;
  logic [31:0] spIn = '0;
  logic        busy, memReq, memWe, memAck = 1'b0, rfWe, spWe;
  logic [31:0] memAddr, memWdata, memRdata, rfRdata, rfWdata, spOut;
  logic [3:0]  rfRdIdx, rfWrIdx;

  logic [31:0] regs[11];
  logic [31:0] mem[256];
  logic [31:0] regSnap[11];
  logic [31:0] expRegs[11];
  logic [31:0] expA[16], expD[16], actA[16], actD[16];
  logic        expW[16], actW[16];
  logic [3:0]  expR[16], actR[16];
  int          expCnt, actCnt, spWeCnt, ackPct = 100;
  logic [31:0] expSp, lastSp;
  int          nChecks = 0, nErr = 0;
  bit          done = 1'b0;

  regstack_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .pushDir(pushDir), .regMask(regMask),
    .spIn(spIn), .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .rfRdIdx(rfRdIdx),
    .rfRdata(rfRdata), .rfWe(rfWe), .rfWrIdx(rfWrIdx), .rfWdata(rfWdata),
    .spWe(spWe), .spOut(spOut)
  );

  always #5 clk = ~clk;

  assign rfRdata  = (rfRdIdx < 4'd11) ? regs[rfRdIdx] : 32'h0;
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (rfWe && rfWrIdx < 4'd11) regs[rfWrIdx] <= rfWdata;
    if (memReq && memAck && memWe) mem[memAddr[9:2]] <= memWdata;
  end

  always @(posedge clk) begin
    #1 memAck = ($urandom_range(99) < ackPct);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memAck) begin
        if (actCnt < 16) begin
          actA[actCnt] = memAddr;
          actW[actCnt] = memWe;
          actD[actCnt] = memWe ? memWdata : memRdata;
          actR[actCnt] = memWe ? rfRdIdx : rfWrIdx;
        end
        actCnt++;
      end
      if (spWe) begin
        spWeCnt++;
        lastSp = spOut;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addExp(input logic [31:0] a, input logic w, input logic [3:0] r);
    expA[expCnt] = a;
    expW[expCnt] = w;
    expR[expCnt] = r;
    expD[expCnt] = w ? regSnap[r] : mem[a[9:2]];
    if (!w) expRegs[r] = mem[a[9:2]];
    expCnt++;
  endtask

  // Reference model built from the order rules of R1..R4.
  task automatic buildExp(input bit push, input logic [7:0] m, input logic [31:0] sp);
    logic [3:0]  single[4];
    logic [3:0]  grp[7];
    logic [31:0] p;
    single = '{4'd2, 4'd3, 4'd6, 4'd7};
    grp    = '{4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10};
    expCnt = 0;
    p = sp;
    for (int i = 0; i < 11; i++) expRegs[i] = regSnap[i];
    if (push) begin
      for (int i = 0; i < 4; i++) if (m[7-i]) begin p = p - 4; addExp(p, 1'b1, single[i]); end
      if (m[3]) begin
        for (int i = 0; i < 7; i++) begin p = p - 4; addExp(p, 1'b1, grp[i]); end
        p = p - 4;
      end
    end else begin
      if (m[3]) begin
        p = p + 4;
        for (int i = 6; i >= 0; i--) begin addExp(p, 1'b0, grp[i]); p = p + 4; end
      end
      for (int i = 3; i >= 0; i--) if (m[7-i]) begin addExp(p, 1'b0, single[i]); p = p + 4; end
    end
    expSp = p;
  endtask

  task automatic runOp(input bit push, input logic [7:0] m, input logic [31:0] sp,
                       input int pct, input bit interfere, input string tag);
    int  guard;
    bit  seqOk;
    ackPct = pct;
    for (int i = 0; i < 11; i++) begin
      regs[i] = $urandom;
      regSnap[i] = regs[i];
    end
    buildExp(push, m, sp);
    actCnt = 0;
    spWeCnt = 0;
    @(negedge clk); #1;
    start = 1'b1; pushDir = push; regMask = m; spIn = sp;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, {"R7 busy after start ", tag}, 32'(busy), 32'd1);
    if (expCnt == 0 && !(m[3] && push))
      chk(spWeCnt == 1, {"R9 immediate write-back ", tag}, 32'(spWeCnt), 32'd1);
    if (interfere && spWeCnt == 0) begin
      start = 1'b1; pushDir = ~push; regMask = 8'hFF; spIn = sp ^ 32'h40;
      @(negedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (spWeCnt == 0 && guard < 3000) begin
      @(negedge clk); #1;
      guard++;
    end
    chk(guard < 3000, {"R5 write-back reached ", tag}, 32'(guard), 32'd0);
    @(negedge clk); #1;
    chk(busy == 1'b0, {"R7 idle after write-back ", tag}, 32'(busy), 32'd0);
    chk(spWeCnt == 1, {"R5 single write-back ", tag}, 32'(spWeCnt), 32'd1);
    chk(lastSp == expSp, {push ? "R3 final pointer " : "R4 final pointer ", tag}, lastSp, expSp);
    chk(actCnt == expCnt, {push ? "R2 word count " : "R4 word count ", tag}, 32'(actCnt), 32'(expCnt));
    seqOk = 1'b1;
    for (int i = 0; i < expCnt && i < 16; i++) begin
      if (actA[i] !== expA[i] || actW[i] !== expW[i] || actR[i] !== expR[i] || actD[i] !== expD[i]) begin
        if (seqOk) $display("FAIL %s R1 step %0d actual=%h/%0d expected=%h/%0d",
                            push ? "R2" : "R4", i, actA[i], actR[i], expA[i], expR[i]);
        seqOk = 1'b0;
      end
    end
    nChecks++;
    if (!seqOk) nErr++;
    for (int i = 0; i < 11; i++)
      chk(regs[i] === expRegs[i], push ? "R10 register unchanged by save" : "R4 restored register",
          regs[i], expRegs[i]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    for (int i = 0; i < 11; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && spWe == 1'b0 && memReq == 1'b0, "R7 reset state", {29'd0, busy, spWe, memReq}, 32'd0);
    rstN = 1'b1;
    // Directed corners
    runOp(1'b1, 8'h00, 32'h200, 100, 1'b0, "R9 zero save");
    runOp(1'b0, 8'h00, 32'h200, 100, 1'b0, "R9 zero restore");
    runOp(1'b1, 8'h07, 32'h204, 100, 1'b0, "R6 low bits save");
    runOp(1'b0, 8'h07, 32'h204, 100, 1'b0, "R6 low bits restore");
    runOp(1'b1, 8'hFF, 32'h300, 100, 1'b0, "R6 full save");
    runOp(1'b0, 8'hFF, 32'h2CC, 100, 1'b0, "R4 full restore");
    runOp(1'b1, 8'h08, 32'h240, 100, 1'b0, "R3 group save");
    runOp(1'b0, 8'h08, 32'h240, 100, 1'b0, "R4 group restore");
    runOp(1'b0, 8'h80, 32'h180, 100, 1'b0, "R1 single restore");
    runOp(1'b1, 8'hF0, 32'h280, 15, 1'b0, "R8 heavy stall save");
    runOp(1'b0, 8'hF8, 32'h180, 15, 1'b0, "R8 heavy stall restore");
    runOp(1'b1, 8'h58, 32'h260, 50, 1'b1, "R7 start while busy save");
    runOp(1'b0, 8'h28, 32'h160, 50, 1'b1, "R7 start while busy restore");
    // Constrained random
    for (int n = 0; n < 40; n++) begin
      runOp(1'($urandom_range(1)), 8'($urandom), 32'h100 + 32'($urandom_range(100)) * 4,
            $urandom_range(20, 100), 1'($urandom_range(1)), "R2 R4 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule